// File: doc/BRIEF.md
# CAN Overload Frame Trigger Detector

This block decides when a CAN controller must start an overload frame. The protocol state machine reports which field the bus is in and the bit position within that field. The bit-timing logic provides each sampled bus level with a one-clock strobe. The detector compares every strobed dominant bit against a small set of trigger positions. When one matches, it raises a single-clock request together with a code that names the condition. The logic that generates the overload flag then acts on that request.

There are five trigger positions:

- the first bit of intermission;
- the second bit of intermission;
- the final bit of end-of-frame, but only while the node is the receiver of that frame;
- the final bit of an error delimiter;
- the final bit of an overload delimiter.

All other positions are ignored, as are all recessive bits. The request comes from a two-state machine. In `REQ_IDLE` no request is shown. A qualifying strobe takes the machine to `REQ_FIRE`, where the request and the cause are shown for one clock. From `REQ_FIRE` the machine returns to `REQ_IDLE`, or stays in `REQ_FIRE` if the next cycle also qualifies.

Top module: `ovl_trigger_det`

## Requirements
- R1: A dominant bit (`bus_bit`=0) strobed while `field`=1 (intermission) at `bit_idx`=0 produces `ovl_req`=1 with `ovl_cause`=1 in the cycle after the strobe edge.
- R2: A dominant bit strobed while `field`=1 at `bit_idx`=1 produces `ovl_req`=1 with `ovl_cause`=2.
- R3: A dominant bit strobed while `field`=2 (end-of-frame) at `bit_idx`=6 with `is_rx`=1 produces `ovl_req`=1 with `ovl_cause`=3.
- R4: The same end-of-frame final-bit dominant sample with `is_rx`=0 produces no request.
- R5: A dominant bit strobed while `field`=3 (error delimiter) at `bit_idx`=7 produces `ovl_req`=1 with `ovl_cause`=4.
- R6: A dominant bit strobed while `field`=4 (overload delimiter) at `bit_idx`=7 produces `ovl_req`=1 with `ovl_cause`=5.
- R7: No other input pattern produces a request. This covers recessive bits, `field`=1 at `bit_idx`=2, non-final bits of end-of-frame or of the delimiters, and field codes 0, 5, 6 and 7.
- R8: Inputs are evaluated only on cycles with `sample_en`=1. Each qualifying strobe gives exactly one request cycle, and `ovl_cause` is 0 whenever `ovl_req` is 0.
- R9: A synchronous `rst` drives `ovl_req` to 0 and `ovl_cause` to 0 at the next edge, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_bit | input | 1 | Sampled bus level, 0 = dominant |
| sample_en | input | 1 | One-clock strobe marking a valid `bus_bit` |
| field | input | 3 | Current frame field: 0 other, 1 intermission, 2 end-of-frame, 3 error delimiter, 4 overload delimiter |
| bit_idx | input | IDX_W (4) | Zero-based bit position inside `field` |
| is_rx | input | 1 | 1 when the node is receiving the current frame |
| ovl_req | output | 1 | One-clock overload frame request |
| ovl_cause | output | 3 | Cause of the request (1..5), 0 when idle |

## Verification
The bench builds the detector with its default parameters:

- a 4-bit index;
- end-of-frame last index 6;
- delimiter last index 7.

With these values, every trigger position and its immediate neighbours can be reached directly. Directed passes place dominant and recessive bits on each trigger, on the third intermission bit and on the transmitted end-of-frame final bit. A biased random pass then checks strobes on consecutive cycles and reset applied while triggers are present against a behavioural model.

// File: rtl/ovl_det_pkg.sv
package ovl_det_pkg;

    typedef enum logic [2:0] {
        FLD_NONE   = 3'd0,
        FLD_IMS    = 3'd1,
        FLD_EOF    = 3'd2,
        FLD_ERRDLM = 3'd3,
        FLD_OVLDLM = 3'd4
    } fld_e;

    typedef enum logic [2:0] {
        CZ_NONE   = 3'd0,
        CZ_IMS1   = 3'd1,
        CZ_IMS2   = 3'd2,
        CZ_EOF    = 3'd3,
        CZ_ERRDLM = 3'd4,
        CZ_OVLDLM = 3'd5
    } cause_e;

    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_FIRE = 1'b1
    } req_st_e;

    localparam int NUM_SLOTS = 5;

endpackage

// File: rtl/ovl_pos_match.sv
module ovl_pos_match #(
    parameter int IDX_W     = 4,
    parameter int MATCH_IDX = 0
) (
    input  logic [IDX_W-1:0] idx,
    output logic             hit
);
    localparam logic [IDX_W-1:0] MATCH_V = IDX_W'(MATCH_IDX);

    assign hit = (idx == MATCH_V);
endmodule

// File: rtl/ovl_cond_decode.sv
module ovl_cond_decode
    import ovl_det_pkg::*;
#(
    parameter int IDX_W      = 4,
    parameter int EOF_LAST   = 6,
    parameter int DELIM_LAST = 7
) (
    input  logic [2:0]       field,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             is_rx,
    input  logic             bus_bit,
    input  logic             sample_en,
    output logic             hit,
    output cause_e           cause
);
    function automatic int slot_idx(int s);
        case (s)
            0:       return 0;
            1:       return 1;
            2:       return EOF_LAST;
            default: return DELIM_LAST;
        endcase
    endfunction

    function automatic logic [2:0] slot_fld(int s);
        case (s)
            0, 1:    return FLD_IMS;
            2:       return FLD_EOF;
            3:       return FLD_ERRDLM;
            default: return FLD_OVLDLM;
        endcase
    endfunction

    logic [NUM_SLOTS-1:0] pos_hit;
    logic [NUM_SLOTS-1:0] slot_ok;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        ovl_pos_match #(
            .IDX_W    (IDX_W),
            .MATCH_IDX(slot_idx(g))
        ) u_match (
            .idx(bit_idx),
            .hit(pos_hit[g])
        );
        if (g == 2) begin : g_rx_gate
            assign slot_ok[g] = pos_hit[g] && (field == slot_fld(g)) && is_rx;
        end else begin : g_plain
            assign slot_ok[g] = pos_hit[g] && (field == slot_fld(g));
        end
    end

    always_comb begin
        cause = CZ_NONE;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_ok[i]) cause = cause_e'(3'(i + 1));
        end
    end

    assign hit = sample_en && !bus_bit && (|slot_ok);
endmodule

// File: rtl/ovl_req_fsm.sv
module ovl_req_fsm
    import ovl_det_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit_i,
    input  cause_e     cause_i,
    output logic       req_o,
    output logic [2:0] cause_o
);
    req_st_e state_q, state_d;
    cause_e  cause_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE: if (hit_i) state_d = REQ_FIRE;
            REQ_FIRE: state_d = hit_i ? REQ_FIRE : REQ_IDLE;
            default:  state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= REQ_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)        cause_q <= CZ_NONE;
        else if (hit_i) cause_q <= cause_i;
        else            cause_q <= CZ_NONE;
    end

    assign req_o   = (state_q == REQ_FIRE);
    assign cause_o = cause_q;

    // R8
    fire_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        req_o |-> $past(hit_i));
    // R8
    idle_cause_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !req_o |-> (cause_o == 3'd0));
endmodule

// File: rtl/ovl_trigger_det.sv
module ovl_trigger_det
    import ovl_det_pkg::*;
#(
    parameter int IDX_W      = 4,
    parameter int EOF_LAST   = 6,
    parameter int DELIM_LAST = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_bit,
    input  logic             sample_en,
    input  logic [2:0]       field,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             is_rx,
    output logic             ovl_req,
    output logic [2:0]       ovl_cause
);
    localparam logic [IDX_W-1:0] EOF_IDX_V   = IDX_W'(EOF_LAST);
    localparam logic [IDX_W-1:0] DELIM_IDX_V = IDX_W'(DELIM_LAST);

    logic   cond_hit;
    cause_e cond_cause;

    ovl_cond_decode #(
        .IDX_W     (IDX_W),
        .EOF_LAST  (EOF_LAST),
        .DELIM_LAST(DELIM_LAST)
    ) u_decode (
        .field    (field),
        .bit_idx  (bit_idx),
        .is_rx    (is_rx),
        .bus_bit  (bus_bit),
        .sample_en(sample_en),
        .hit      (cond_hit),
        .cause    (cond_cause)
    );

    ovl_req_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .hit_i  (cond_hit),
        .cause_i(cond_cause),
        .req_o  (ovl_req),
        .cause_o(ovl_cause)
    );

    // R7
    dominant_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ovl_req |-> ($past(sample_en) && !$past(bus_bit)));
    // R4
    no_tx_eof_chk: assert property (@(posedge clk) disable iff (rst)
        (ovl_req && ovl_cause == 3'd3) |-> ($past(is_rx) && $past(bit_idx) == EOF_IDX_V));
    // R2
    ims_second_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (ovl_req && ovl_cause == 3'd2) |-> ($past(field) == 3'd1 && $past(bit_idx) == 1));
    // R6
    ovl_delim_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (ovl_req && ovl_cause == 3'd5) |-> ($past(field) == 3'd4 && $past(bit_idx) == DELIM_IDX_V));
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!ovl_req && ovl_cause == 3'd0));
endmodule

// File: tb/sim_ovl_trigger_det.sv
module sim_ovl_trigger_det;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_bit = 1'b1;
    logic             sample_en = 1'b0;
    logic [2:0]       field = 3'd0;
    logic [IDX_W-1:0] bit_idx = '0;
    logic             is_rx = 1'b0;
    logic             ovl_req;
    logic [2:0]       ovl_cause;

    int    errors = 0;
    int    checks = 0;
    bit    armed  = 1'b0;
    bit    done   = 1'b0;
    bit    m_req;
    int    m_cause;
    string m_tag;

    always #2 clk = ~clk;

    ovl_trigger_det #(.IDX_W(IDX_W)) u0 (
        .clk(clk), .rst(rst), .bus_bit(bus_bit), .sample_en(sample_en),
        .field(field), .bit_idx(bit_idx), .is_rx(is_rx),
        .ovl_req(ovl_req), .ovl_cause(ovl_cause)
    );

    // Behavioural reference: R1 R2 R3 R5 R6 set a cause, R4 R7 R8 none, R9 reset
    always @(posedge clk) begin
        m_req   = 1'b0;
        m_cause = 0;
        if (rst) begin
            m_tag = "R9";
        end else begin
            if (sample_en && bus_bit == 1'b0) begin
                if (field == 1 && bit_idx == 0)               m_cause = 1;
                else if (field == 1 && bit_idx == 1)          m_cause = 2;
                else if (field == 2 && bit_idx == 6 && is_rx) m_cause = 3;
                else if (field == 3 && bit_idx == 7)          m_cause = 4;
                else if (field == 4 && bit_idx == 7)          m_cause = 5;
            end
            m_req = (m_cause != 0);
            if (m_req) m_tag = $sformatf("R%0d", (m_cause < 4) ? m_cause : m_cause + 1);
            else if (sample_en && !bus_bit && field == 2 && bit_idx == 6) m_tag = "R4";
            else if (!sample_en) m_tag = "R8";
            else m_tag = "R7";
        end
        armed = 1'b1;
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (ovl_req !== m_req || ovl_cause !== 3'(m_cause)) begin
                errors++;
                $display("FAIL %s: req=%0b cause=%0d expected req=%0b cause=%0d",
                         m_tag, ovl_req, ovl_cause, m_req, m_cause);
            end
        end
    end

    task automatic drive(input int f, input int i, input bit b, input bit s, input bit rx);
        @(negedge clk);
        field = 3'(f); bit_idx = IDX_W'(i); bus_bit = b; sample_en = s; is_rx = rx;
    endtask

    task automatic quiet();
        drive(0, 0, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        // R9: trigger present during reset
        drive(1, 0, 1'b0, 1'b1, 1'b1);
        drive(4, 7, 1'b0, 1'b1, 1'b1);
        @(negedge clk); rst = 1'b0;
        quiet();
        // R1, R2, third bit (R7)
        drive(1, 0, 1'b0, 1'b1, 1'b0); quiet();
        drive(1, 1, 1'b0, 1'b1, 1'b0); quiet();
        drive(1, 2, 1'b0, 1'b1, 1'b1); quiet();
        // R3 and R4
        drive(2, 6, 1'b0, 1'b1, 1'b1); quiet();
        drive(2, 6, 1'b0, 1'b1, 1'b0); quiet();
        drive(2, 5, 1'b0, 1'b1, 1'b1); quiet();
        // R5, R6 and earlier delimiter bits (R7)
        drive(3, 7, 1'b0, 1'b1, 1'b0); quiet();
        drive(4, 7, 1'b0, 1'b1, 1'b1); quiet();
        drive(3, 6, 1'b0, 1'b1, 1'b0); quiet();
        drive(4, 0, 1'b0, 1'b1, 1'b0); quiet();
        // R7 recessive on triggers, R8 no strobe
        drive(1, 0, 1'b1, 1'b1, 1'b1); quiet();
        drive(3, 7, 1'b0, 1'b0, 1'b1); quiet();
        // R8 strobes on consecutive cycles
        drive(1, 0, 1'b0, 1'b1, 1'b0);
        drive(1, 1, 1'b0, 1'b1, 1'b0);
        quiet(); quiet();
        // biased random pass with occasional reset (R9)
        for (int n = 0; n < 4000; n++) begin
            int f, i;
            f = $urandom_range(0, 7);
            case ($urandom_range(0, 3))
                0:       i = $urandom_range(0, 2);
                1:       i = 6;
                2:       i = 7;
                default: i = $urandom_range(0, 15);
            endcase
            drive(f, i, 1'($urandom_range(0, 2) != 0 ? 0 : 1),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            rst = ($urandom_range(0, 99) == 0);
        end
        rst = 1'b0;
        quiet(); quiet();
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: req=%0b cause=%0d expected run to finish", ovl_req, ovl_cause);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule